// File: doc/BRIEF.md
# Dual-Clock FIFO with Encoded Fill-Level Code

This block is a first-in first-out buffer for 9-bit words. Its write port and its read port run on separate clocks. Each side reports its own fill level on a 2-bit level code that distinguishes four views: nearly empty or empty, mid-range, nearly full, and full. The code changes only on clock edges. Every edge of either clock refreshes that clock's half of the code, whether or not a transfer happens on that edge. An idle port can therefore bring its view up to date after activity on the other port. An active-low asynchronous master reset empties the buffer.

Both data ports use valid/ready handshakes. A word is written on a rising `wclk` edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls only while the write side sees the buffer full. The writer must then hold or withdraw its word, and the word is not stored. A word is consumed on a rising `rclk` edge where `rd_valid` and `rd_ready` are both high. `rd_data` shows the oldest word whenever `rd_valid` is high.

Pointers cross between the two clock domains through a synchroniser chain of `SYNC_STAGES` flops. The parameter `LATE_EDGE` adds one stage. It models an opposite-port edge that arrives too close to count and so is taken in one cycle later.

Top module: `clkfifo_flags`

## Requirements
- R1: While `rst_n` is low and right after it is released, `level_code` is 2'b00, `rd_valid` is 0 and `wr_ready` is 1.
- R2: Words leave in the order they were accepted, with all 9 bits unchanged.
- R3: When the write side sees DEPTH words stored, `wr_ready` is 0 and a held `wr_valid` stores nothing. No stored word is overwritten.
- R4: When the read side sees zero words, `rd_valid` is 0. A held `rd_ready` does not move the read position.
- R5: After both clocks have run idle for a few edges, `level_code` follows the stored count N. It is 2'b00 for N from 0 to MARGIN, 2'b11 for N from MARGIN+1 to DEPTH-MARGIN-1, 2'b10 for N from DEPTH-MARGIN to DEPTH-1, and 2'b01 for N equal to DEPTH. Bit 1 and bit 0 are the two flag pins.
- R6: While the read port is idle, a write that brings the count to DEPTH-MARGIN shows 2'b10 right after that same `wclk` edge.
- R7: If reads take the count below DEPTH-MARGIN while `wclk` is stopped, the code stays 2'b10. It leaves 2'b10 only on the (SYNC_STAGES+1)-th later `wclk` edge, and those edges may all carry `wr_valid` low.
- R8: After a write into an empty buffer, `rd_valid` rises on the (SYNC_STAGES+1)-th `rclk` edge and not before, when LATE_EDGE is 0.
- R9: When LATE_EDGE is 1, each crossing takes one more edge of the receiving clock, so R8 becomes the (SYNC_STAGES+2)-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| wr_valid | input | 1 | Writer offers a word |
| wr_ready | output | 1 | Buffer can accept a word |
| wr_data | input | DW | Word offered |
| rd_valid | output | 1 | A word is available |
| rd_ready | input | 1 | Reader takes the word |
| rd_data | output | DW | Oldest stored word |
| level_code | output | 2 | Fill-level code (R5) |

## Verification
A write and a read can complete on the same instant when both clocks share edges. In that cycle the write side updates its near-full view and the read side updates its near-empty view from pointers that are both moving. The bench provokes this by running both handshakes high for a long stretch with the buffer mid-range. It checks every word read against a queue model and then compares the settled level code with the model's count. The boundary runs stop one clock and step the other to show how late a view catches up.

// File: rtl/cff_pkg.sv
package cff_pkg;
  typedef enum logic [1:0] {WS_ROOM, WS_NEAR, WS_FULL} wview_t;
  typedef enum logic [1:0] {RS_EMPTY, RS_LOW, RS_MID} rview_t;

  localparam logic [1:0] CODE_LOW  = 2'b00;
  localparam logic [1:0] CODE_FULL = 2'b01;
  localparam logic [1:0] CODE_NEAR = 2'b10;
  localparam logic [1:0] CODE_MID  = 2'b11;
endpackage

// File: rtl/cff_sync.sv
module cff_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2,
  parameter bit EXTRA  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int N = STAGES + (EXTRA ? 1 : 0);

  logic [W-1:0] stg [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < N; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[N-1];
endmodule

// File: rtl/cff_wside.sv
module cff_wside
  import cff_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int MARGIN = 16,
  parameter int PW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [PW-1:0] rgray_s,
  output logic          push,
  output logic          ready,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output wview_t        view
);
  localparam logic [PW-1:0] FULLV = PW'(DEPTH);
  localparam logic [PW-1:0] NEARV = PW'(DEPTH - MARGIN);

  logic [PW-1:0] rbin_s, wbin_nx, fill;
  wview_t        view_nx;

  always_comb begin
    rbin_s[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign push    = push_req && (view != WS_FULL);
  assign wbin_nx = wbin + PW'(push);
  assign fill    = wbin_nx - rbin_s;

  always_comb begin
    if (fill == FULLV)      view_nx = WS_FULL;
    else if (fill >= NEARV) view_nx = WS_NEAR;
    else                    view_nx = WS_ROOM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      view  <= WS_ROOM;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      view  <= view_nx;
    end
  end

  assign ready = (view != WS_FULL);
endmodule

// File: rtl/cff_rside.sv
module cff_rside
  import cff_pkg::*;
#(
  parameter int MARGIN = 16,
  parameter int PW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_req,
  input  logic [PW-1:0] wgray_s,
  output logic          valid,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output rview_t        view
);
  localparam logic [PW-1:0] LOWV = PW'(MARGIN);

  logic [PW-1:0] wbin_s, rbin_nx, fill;
  logic          pop;
  rview_t        view_nx;

  always_comb begin
    wbin_s[PW-1] = wgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign pop     = pop_req && (view != RS_EMPTY);
  assign rbin_nx = rbin + PW'(pop);
  assign fill    = wbin_s - rbin_nx;

  always_comb begin
    if (fill == '0)        view_nx = RS_EMPTY;
    else if (fill <= LOWV) view_nx = RS_LOW;
    else                   view_nx = RS_MID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      view  <= RS_EMPTY;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      view  <= view_nx;
    end
  end

  assign valid = (view != RS_EMPTY);
endmodule

// File: rtl/clkfifo_flags.sv
module clkfifo_flags
  import cff_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int DW          = 9,
  parameter int MARGIN      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit LATE_EDGE   = 1'b0
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    level_code
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic          push;
  wview_t        wview;
  rview_t        rview;
  logic [DW-1:0] mem [DEPTH];

  cff_sync #(.W(PW), .STAGES(SYNC_STAGES), .EXTRA(LATE_EDGE)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  cff_sync #(.W(PW), .STAGES(SYNC_STAGES), .EXTRA(LATE_EDGE)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  cff_wside #(.DEPTH(DEPTH), .MARGIN(MARGIN), .PW(PW)) u_wside (
    .clk(wclk), .rst_n(rst_n), .push_req(wr_valid), .rgray_s(rgray_s),
    .push(push), .ready(wr_ready), .wbin(wbin), .wgray(wgray), .view(wview)
  );

  cff_rside #(.MARGIN(MARGIN), .PW(PW)) u_rside (
    .clk(rclk), .rst_n(rst_n), .pop_req(rd_ready), .wgray_s(wgray_s),
    .valid(rd_valid), .rbin(rbin), .rgray(rgray), .view(rview)
  );

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rbin[AW-1:0]];

  always_comb begin
    if (wview == WS_FULL)      level_code = CODE_FULL;
    else if (wview == WS_NEAR) level_code = CODE_NEAR;
    else if (rview == RS_MID)  level_code = CODE_MID;
    else                       level_code = CODE_LOW;
  end
endmodule

// File: rtl/clkfifo_flags_chk.sv
module clkfifo_flags_chk #(
  parameter int PW = 10
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [1:0]    level_code,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  // R2: an accepted write advances the write position by exactly one
  a_r2_write_step: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (wbin == $past(wbin) + 1'b1));

  // R2: an accepted read advances the read position by exactly one
  a_r2_read_step: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> (rbin == $past(rbin) + 1'b1));

  // R3: an offer refused while full leaves the write position alone
  a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_ready) |=> $stable(wbin));

  // R3: back-pressure only ever coincides with the full code
  a_r3_full_code: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_ready) |-> (level_code == 2'b01));

  // R4: a read attempt while empty leaves the read position alone
  a_r4_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_valid) |=> $stable(rbin));

  // R7: crossing pointers change by at most one bit per edge
  a_r7_wgray_onebit: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R8: same for the read pointer carried to the write side
  a_r8_rgray_onebit: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind clkfifo_flags clkfifo_flags_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready),
  .level_code(level_code),
  .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray)
);

// File: tb/sim_clkfifo_flags.sv
`timescale 1ns/1ps
module sim_clkfifo_flags;
  localparam int DEPTH  = 512;
  localparam int DW     = 9;
  localparam int MARGIN = 16;

  logic clk = 1'b0;
  logic wg = 1'b0, rg = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wclk, rclk;
  logic wr_ready, rd_valid, u1_wr_ready, u1_rd_valid;
  logic [DW-1:0] rd_data, u1_rd_data;
  logic [1:0] level_code, u1_level_code;

  int tests = 0, fails = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] dval = 9'h0A5;

  always #2 clk = ~clk;
  assign wclk = clk & wg;
  assign rclk = clk & rg;

  clkfifo_flags #(.DEPTH(DEPTH), .DW(DW), .MARGIN(MARGIN)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .level_code(level_code)
  );

  clkfifo_flags #(.DEPTH(DEPTH), .DW(DW), .MARGIN(MARGIN), .LATE_EDGE(1'b1)) u1 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(u1_wr_ready), .wr_data(wr_data),
    .rd_valid(u1_rd_valid), .rd_ready(rd_ready), .rd_data(u1_rd_data),
    .level_code(u1_level_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] code_for(input int n);
    if (n == DEPTH) return 2'b01;
    if (n >= DEPTH - MARGIN) return 2'b10;
    if (n > MARGIN) return 2'b11;
    return 2'b00;
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(input bit we, input bit re, input bit wgo, input bit rgo);
    wg = wgo; rg = rgo;
    wr_valid = we; rd_ready = re; wr_data = dval;
    if (wgo && we && wr_ready) begin
      q.push_back(dval);
      dval = dval + 9'd37;
    end
    if (rgo && re && rd_valid) begin
      chk(q.size() > 0 && rd_data == q[0], "R2", int'(rd_data), (q.size() > 0) ? int'(q[0]) : -1);
      if (q.size() > 0) void'(q.pop_front());
    end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 1);
  endtask

  task automatic fill_to(input int n);
    while (q.size() < n) cyc(1, 0, 1, 1);
  endtask

  task automatic drain();
    while (q.size() > 0) cyc(0, 1, 1, 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    @(negedge clk);
    wg = 1'b1; rg = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(level_code == 2'b00, "R1 code", level_code, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(level_code == 2'b00 && !rd_valid && wr_ready, "R1 after release", level_code, 0);

    // R8/R9: one write into empty, read clock only
    cyc(1, 0, 1, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    chk(rd_valid == 1'b0, "R8 two edges", rd_valid, 0);
    cyc(0, 0, 0, 1);
    chk(rd_valid == 1'b1, "R8 third edge", rd_valid, 1);
    chk(u1_rd_valid == 1'b0, "R9 late third edge", u1_rd_valid, 0);
    cyc(0, 0, 0, 1);
    chk(u1_rd_valid == 1'b1, "R9 late fourth edge", u1_rd_valid, 1);
    settle();
    drain();
    settle();

    // R4: read attempts while empty
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1);
    chk(rd_valid == 1'b0, "R4 empty", rd_valid, 0);
    fill_to(1);
    settle();
    drain();
    settle();

    // R5: low-end thresholds MARGIN-1, MARGIN, MARGIN+1
    for (int n = MARGIN - 1; n <= MARGIN + 1; n++) begin
      fill_to(n);
      settle();
      chk(level_code == code_for(n), "R5 low threshold", level_code, code_for(n));
    end
    drain();
    settle();
    chk(level_code == 2'b00 && !rd_valid, "R5 drained", level_code, 0);

    // R5/R6: near-full threshold
    fill_to(DEPTH - MARGIN - 1);
    settle();
    chk(level_code == 2'b11, "R5 below near-full", level_code, 3);
    cyc(1, 0, 1, 1);
    chk(level_code == 2'b10, "R6 same edge", level_code, 2);

    // R7: reads with write clock stopped
    while (q.size() > DEPTH - MARGIN - 2) cyc(0, 1, 0, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);
    chk(level_code == 2'b10, "R7 held", level_code, 2);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    chk(level_code == 2'b10, "R7 two idle wclk", level_code, 2);
    cyc(0, 0, 1, 0);
    chk(level_code == 2'b11, "R7 third idle wclk", level_code, 3);
    settle();

    // R3/R5: full and held offers
    fill_to(DEPTH);
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 1);
    chk(q.size() == DEPTH, "R3 model count", q.size(), DEPTH);
    chk(wr_ready == 1'b0, "R3 ready low", wr_ready, 0);
    chk(level_code == 2'b01, "R5 full code", level_code, 1);
    drain();
    settle();
    chk(level_code == 2'b00 && wr_ready, "R3 after drain", level_code, 0);

    // Concurrent write and read at shared edges
    fill_to(40);
    for (int i = 0; i < 300; i++) cyc(1, (i % 3) != 0, 1, 1);
    settle();
    chk(level_code == code_for(q.size()), "R5 after concurrent", level_code, code_for(q.size()));
    drain();
    settle();
    chk(level_code == 2'b00 && !rd_valid, "R2 final empty", level_code, 0);

    summary();
  end
endmodule